// File: doc/BRIEF.md
# Debug Port Mode Arbiter and Key Gate

This block sits between two debug physical layers and the debug controller. One layer is a dedicated two-wire link and the other is JTAG. The block chooses which layer is active and always prefers the two-wire layer. It selects the matching clock and pulses a controller reset each time the active mode changes, whether the change is an entry, a handover or a drop to idle.

The block also guards the internal bus. While a mode is active, the bus stays closed until a key strobe presents the full 64-bit key value. Once opened, the block is in programming mode. Requests aimed at the nonvolatile memory space are granted only while the memory controller reports that it is enabled.

Losing any condition of the grant closes the gate again, and a fresh key is then needed. The conditions are the active layer, the reset, and the memory controller enable.

Top module: `dbgModeGate`

## Requirements
- R1: While rstN is low, mode and clkSel read 2'b00, and ctlReset, progMode and busGrant read 0.
- R2: One clock after the enables are sampled, mode reads 2'b01 when wireEn is high, 2'b10 when only jtagEn is high, and 2'b00 when neither is high.
- R3: clkSel reads 2'b00 (no clock) in idle, 2'b01 (dedicated debug clock) in two-wire mode and 2'b10 (TCK) in JTAG mode, in the same cycle that mode shows.
- R4: ctlReset is high for exactly the one cycle in which a new mode value first appears. It is low in every other cycle.
- R5: Raising wireEn while in JTAG mode moves mode to 2'b01 at the next clock edge, with a ctlReset pulse, even though jtagEn stays high.
- R6: A keyStrobe carrying keyValue equal to the KEY_VALUE parameter sets progMode at the next edge. This happens only when mode is not idle, the mode is not changing, and nvmCtlEn is high.
- R7: A keyStrobe carrying any other keyValue leaves progMode and every other output unchanged.
- R8: A keyStrobe is ignored in idle, in a cycle in which the mode changes, and while nvmCtlEn is low.
- R9: progMode clears at the next edge when the mode changes, when the mode goes to idle, or when nvmCtlEn is low. It stays clear until a new correct key arrives.
- R10: busGrant is combinational and equals busReq AND progMode AND (busIsNvm low, or nvmCtlEn high).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wireEn | input | 1 | Two-wire debug layer enabled (higher priority) |
| jtagEn | input | 1 | JTAG layer enabled |
| keyStrobe | input | 1 | Key instruction strobe, one cycle |
| keyValue | input | 64 | Key presented with the strobe |
| nvmCtlEn | input | 1 | Memory controller reports enabled |
| busReq | input | 1 | Internal bus request |
| busIsNvm | input | 1 | Request targets the nonvolatile memory space |
| mode | output | 2 | Active mode: 00 idle, 01 two-wire, 10 JTAG |
| clkSel | output | 2 | Clock select: 00 none, 01 debug clock, 10 TCK |
| ctlReset | output | 1 | One-cycle controller reset on a mode change |
| progMode | output | 1 | Gate open (programming mode) |
| busGrant | output | 1 | Bus request granted |

## Verification
Two events can land in the same cycle: a correct key strobe and a mode change. The change can be a handover from JTAG to the two-wire layer or a drop to idle. In that cycle the reset must win, and progMode must stay or become clear.

The bench provokes this by raising wireEn in the same cycle as a valid key strobe. It repeats the case with a strobe issued while nvmCtlEn falls. In both cases the cycle-level reference model expects the gate closed after the edge, and the bench compares every output on every clock.

// File: rtl/dbg_pkg.sv
package dbg_pkg;
  typedef enum logic [1:0] {
    MODE_IDLE = 2'b00,
    MODE_WIRE = 2'b01,
    MODE_JTAG = 2'b10
  } dbgMode_t;

  typedef enum logic [1:0] {
    CLK_NONE = 2'b00,
    CLK_WIRE = 2'b01,
    CLK_TCK  = 2'b10
  } dbgClk_t;

  // strobes passed from control to the key datapath
  typedef struct packed {
    logic clearLock;   // close the gate at the next edge
    logic keyWindow;   // a key strobe may open the gate
  } ctlStrobe_t;
endpackage

// File: rtl/dbgModeCtl.sv
module dbgModeCtl
  import dbg_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wireEn,
  input  logic       jtagEn,
  input  logic       nvmCtlEn,
  output dbgMode_t   modeQ,
  output dbgClk_t    clkSel,
  output logic       ctlReset,
  output ctlStrobe_t strobe
);
  dbgMode_t modeNext;
  logic     modeChange;

  // fixed priority: two-wire layer over JTAG
  always_comb begin
    if (wireEn)      modeNext = MODE_WIRE;
    else if (jtagEn) modeNext = MODE_JTAG;
    else             modeNext = MODE_IDLE;
  end

  assign modeChange = (modeNext != modeQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ    <= MODE_IDLE;
      ctlReset <= 1'b0;
    end else begin
      modeQ    <= modeNext;
      ctlReset <= modeChange;
    end
  end

  always_comb begin
    unique case (modeQ)
      MODE_WIRE: clkSel = CLK_WIRE;
      MODE_JTAG: clkSel = CLK_TCK;
      default:   clkSel = CLK_NONE;
    endcase
  end

  always_comb begin
    strobe.clearLock = modeChange || (modeNext == MODE_IDLE) || !nvmCtlEn;
    strobe.keyWindow = !strobe.clearLock;
  end
endmodule

// File: rtl/dbgKeyPath.sv
module dbgKeyPath
  import dbg_pkg::*;
#(
  parameter int              KEY_WIDTH   = 64,
  parameter int              CHUNK_WIDTH = 16,
  parameter logic [KEY_WIDTH-1:0] KEY_VALUE = 64'h1F2E_3D4C_5B6A_7988
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 keyStrobe,
  input  logic [KEY_WIDTH-1:0] keyValue,
  input  logic                 nvmCtlEn,
  input  logic                 busReq,
  input  logic                 busIsNvm,
  input  ctlStrobe_t           strobe,
  output logic                 progMode,
  output logic                 busGrant
);
  localparam int NUM_CHUNKS = (KEY_WIDTH + CHUNK_WIDTH - 1) / CHUNK_WIDTH;
  localparam int PAD_WIDTH  = NUM_CHUNKS * CHUNK_WIDTH;

  logic [PAD_WIDTH-1:0]  keyPad;
  logic [PAD_WIDTH-1:0]  refPad;
  logic [NUM_CHUNKS-1:0] chunkHit;
  logic                  keyMatch;

  assign keyPad = PAD_WIDTH'(keyValue);
  assign refPad = PAD_WIDTH'(KEY_VALUE);

  // the key compare is split into narrow slices, then AND-reduced
  for (genvar i = 0; i < NUM_CHUNKS; i++) begin : g_chunk
    assign chunkHit[i] = (keyPad[i*CHUNK_WIDTH +: CHUNK_WIDTH] ==
                          refPad[i*CHUNK_WIDTH +: CHUNK_WIDTH]);
  end

  assign keyMatch = &chunkHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                       progMode <= 1'b0;
    else if (strobe.clearLock)                       progMode <= 1'b0;
    else if (strobe.keyWindow && keyStrobe && keyMatch) progMode <= 1'b1;
  end

  assign busGrant = busReq && progMode && (!busIsNvm || nvmCtlEn);
endmodule

// File: rtl/dbgModeGate.sv
module dbgModeGate
  import dbg_pkg::*;
#(
  parameter int KEY_WIDTH   = 64,
  parameter int CHUNK_WIDTH = 16,
  parameter logic [KEY_WIDTH-1:0] KEY_VALUE = 64'h1F2E_3D4C_5B6A_7988
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wireEn,
  input  logic                 jtagEn,
  input  logic                 keyStrobe,
  input  logic [KEY_WIDTH-1:0] keyValue,
  input  logic                 nvmCtlEn,
  input  logic                 busReq,
  input  logic                 busIsNvm,
  output logic [1:0]           mode,
  output logic [1:0]           clkSel,
  output logic                 ctlReset,
  output logic                 progMode,
  output logic                 busGrant
);
  dbgMode_t   modeQ;
  dbgClk_t    clkQ;
  ctlStrobe_t strobe;

  dbgModeCtl u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .wireEn   (wireEn),
    .jtagEn   (jtagEn),
    .nvmCtlEn (nvmCtlEn),
    .modeQ    (modeQ),
    .clkSel   (clkQ),
    .ctlReset (ctlReset),
    .strobe   (strobe)
  );

  dbgKeyPath #(
    .KEY_WIDTH   (KEY_WIDTH),
    .CHUNK_WIDTH (CHUNK_WIDTH),
    .KEY_VALUE   (KEY_VALUE)
  ) u_key (
    .clk       (clk),
    .rstN      (rstN),
    .keyStrobe (keyStrobe),
    .keyValue  (keyValue),
    .nvmCtlEn  (nvmCtlEn),
    .busReq    (busReq),
    .busIsNvm  (busIsNvm),
    .strobe    (strobe),
    .progMode  (progMode),
    .busGrant  (busGrant)
  );

  assign mode   = modeQ;
  assign clkSel = clkQ;
endmodule

// File: rtl/dbgModeGateChk.sv
module dbgModeGateChk #(
  parameter int KEY_WIDTH = 64,
  parameter logic [KEY_WIDTH-1:0] KEY_VALUE = 64'h1F2E_3D4C_5B6A_7988
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 wireEn,
  input logic                 jtagEn,
  input logic                 keyStrobe,
  input logic [KEY_WIDTH-1:0] keyValue,
  input logic                 nvmCtlEn,
  input logic                 busReq,
  input logic [1:0]           mode,
  input logic [1:0]           clkSel,
  input logic                 ctlReset,
  input logic                 progMode,
  input logic                 busGrant
);
  always_comb begin
    if (!rstN) AST_RESET_STATE: assert (mode == 2'b00 && !progMode && !ctlReset); // R1
  end

  AST_WIRE_PRIORITY: assert property (@(posedge clk) disable iff (!rstN)
    wireEn |=> mode == 2'b01); // R5
  AST_JTAG_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    (!wireEn && jtagEn) |=> mode == 2'b10); // R2
  AST_IDLE_NO_CLOCK: assert property (@(posedge clk) disable iff (!rstN)
    mode == 2'b00 |-> (clkSel == 2'b00 && !progMode)); // R3
  AST_RESET_ON_CHANGE: assert property (@(posedge clk) disable iff (!rstN)
    (mode != $past(mode)) |-> ctlReset); // R4
  AST_KEY_OPENS: assert property (@(posedge clk) disable iff (!rstN)
    $rose(progMode) |-> $past(keyStrobe && keyValue == KEY_VALUE)); // R6
  AST_NVM_DROP_LOCKS: assert property (@(posedge clk) disable iff (!rstN)
    !nvmCtlEn |=> !progMode); // R9
  AST_GRANT_NEEDS_OPEN: assert property (@(posedge clk) disable iff (!rstN)
    busGrant |-> (progMode && busReq)); // R10
endmodule

bind dbgModeGate dbgModeGateChk #(.KEY_WIDTH(KEY_WIDTH), .KEY_VALUE(KEY_VALUE)) u_chk (
  .clk(clk), .rstN(rstN), .wireEn(wireEn), .jtagEn(jtagEn),
  .keyStrobe(keyStrobe), .keyValue(keyValue), .nvmCtlEn(nvmCtlEn),
  .busReq(busReq), .mode(mode), .clkSel(clkSel), .ctlReset(ctlReset),
  .progMode(progMode), .busGrant(busGrant)
);

// File: tb/dbgModeGate_bench.sv
module dbgModeGate_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] KEY = 64'h1F2E_3D4C_5B6A_7988;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wireEn = 0, jtagEn = 0, keyStrobe = 0, nvmCtlEn = 0;
  logic        busReq = 0, busIsNvm = 0;
  logic [63:0] keyValue = '0;
  logic [1:0]  mode, clkSel;
  logic        ctlReset, progMode, busGrant;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  // reference model state
  int expMode = 0;
  bit expOpen = 0;
  bit expRst  = 0;

  dbgModeGate u_dbgModeGate (
    .clk(clk), .rstN(rstN), .wireEn(wireEn), .jtagEn(jtagEn),
    .keyStrobe(keyStrobe), .keyValue(keyValue), .nvmCtlEn(nvmCtlEn),
    .busReq(busReq), .busIsNvm(busIsNvm), .mode(mode), .clkSel(clkSel),
    .ctlReset(ctlReset), .progMode(progMode), .busGrant(busGrant)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cycles);
    end
  endtask

  task automatic compareAll();
    int g;
    g = (busReq && expOpen && (!busIsNvm || nvmCtlEn)) ? 1 : 0;
    check("R2 mode", int'(mode), expMode);
    check("R3 clkSel", int'(clkSel), expMode);
    check("R4 ctlReset", int'(ctlReset), int'(expRst));
    check("R9 progMode", int'(progMode), int'(expOpen));
    check("R10 busGrant", int'(busGrant), g);
  endtask

  // one clock: predict from sampled inputs, step, compare
  task automatic cyc();
    int  nm;
    bit  chg, nOpen;
    nm  = wireEn ? 1 : (jtagEn ? 2 : 0);
    chg = (nm != expMode);
    if (chg || nm == 0 || !nvmCtlEn) nOpen = 0;
    else if (keyStrobe && keyValue == KEY) nOpen = 1;
    else nOpen = expOpen;
    @(posedge clk);
    #(CLK_PERIOD/4);
    cycles++;
    expMode = nm; expRst = chg; expOpen = nOpen;
    compareAll();
  endtask

  task automatic sendKey(logic [63:0] k);
    keyStrobe = 1; keyValue = k;
    cyc();
    keyStrobe = 0; keyValue = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // R1 reset state, with enables and key active during reset
    wireEn = 1; keyStrobe = 1; keyValue = KEY; nvmCtlEn = 1; busReq = 1;
    repeat (3) @(posedge clk);
    #(CLK_PERIOD/4);
    check("R1 mode", int'(mode), 0);
    check("R1 clkSel", int'(clkSel), 0);
    check("R1 ctlReset", int'(ctlReset), 0);
    check("R1 progMode", int'(progMode), 0);
    check("R1 busGrant", int'(busGrant), 0);
    wireEn = 0; keyStrobe = 0; keyValue = '0; busReq = 0;
    rstN = 1;
    cyc(); cyc();

    // R2 JTAG entry, R3 clock select TCK
    jtagEn = 1; cyc();
    check("R2 jtag entry", int'(mode), 2);
    check("R3 tck select", int'(clkSel), 2);
    check("R4 entry pulse", int'(ctlReset), 1);
    cyc();
    check("R4 single pulse", int'(ctlReset), 0);

    // R10 locked: no grant
    busReq = 1; busIsNvm = 0; cyc();
    check("R10 locked deny", int'(busGrant), 0);

    // R7 wrong key
    sendKey(KEY ^ 64'h0001_0000_0000_0000);
    check("R7 wrong key", int'(progMode), 0);
    sendKey(KEY ^ 64'h1);
    check("R7 wrong key low bit", int'(progMode), 0);
    check("R7 mode unchanged", int'(mode), 2);

    // R6 correct key
    sendKey(KEY);
    check("R6 unlock", int'(progMode), 1);
    check("R10 grant", int'(busGrant), 1);
    busIsNvm = 1; cyc();
    check("R10 nvm grant", int'(busGrant), 1);

    // R10/R9 nvm controller off: grant drops at once, gate closes
    nvmCtlEn = 0; #1;
    check("R10 nvm disabled deny", int'(busGrant), 0);
    cyc();
    check("R9 nvm drop clears", int'(progMode), 0);
    nvmCtlEn = 1; cyc();
    check("R9 stays clear", int'(progMode), 0);

    // R8 key while nvmCtlEn low
    nvmCtlEn = 0; sendKey(KEY);
    check("R8 key nvm low", int'(progMode), 0);
    nvmCtlEn = 1; cyc();

    // reopen, then R5 handover collides with key strobe
    sendKey(KEY);
    check("R6 reopen", int'(progMode), 1);
    wireEn = 1; sendKey(KEY);
    check("R5 handover", int'(mode), 1);
    check("R5 handover pulse", int'(ctlReset), 1);
    check("R8 key in change cycle", int'(progMode), 0);
    check("R3 debug clock", int'(clkSel), 1);
    cyc();
    sendKey(KEY);
    check("R6 unlock wire", int'(progMode), 1);

    // drop wire while jtag still on: back to JTAG, gate closes
    wireEn = 0; cyc();
    check("R2 fall back jtag", int'(mode), 2);
    check("R9 change clears", int'(progMode), 0);

    // both off: idle, R8 key ignored in idle
    jtagEn = 0; cyc();
    check("R2 idle", int'(mode), 0);
    check("R3 no clock", int'(clkSel), 0);
    sendKey(KEY);
    check("R8 key in idle", int'(progMode), 0);
    busIsNvm = 0; cyc();
    check("R10 idle deny", int'(busGrant), 0);

    // pattern sweep over enables with keys
    for (int i = 0; i < 40; i++) begin
      wireEn   = (i % 7 == 3);
      jtagEn   = (i % 5 != 0);
      nvmCtlEn = (i % 11 != 10);
      busIsNvm = i[0];
      busReq   = i[1] | i[2];
      if (i % 3 == 1) sendKey(i % 9 == 4 ? ~KEY : KEY);
      else cyc();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule